// File: doc/BRIEF.md
# Prescaled Up-Counter with Coherent Snapshot

This block is a time base. A 14-bit programmable prescaler divides a chosen input rate and gives a one-clock tick pulse. The input rate is either every system clock cycle or the cycles in which an external clock-enable is high. A 33-bit counter counts up by one for each tick and wraps to zero after its all-ones value. Each wrap gives a one-cycle pulse.

Software sees the live count as a 33-bit output and can overwrite any one of its three words. A read of the live count in several bus accesses can tear while the counter runs. For that reason, a snapshot command copies all 33 bits in one edge into a shadow register. The shadow register is shown as two 16-bit words and one 1-bit word, and software reads those instead.

Other blocks can use the tick output as a shared rate enable.

Top module: `tick_timebase`

## Requirements
- R1: With `rst_n` low at a rising clock edge (synchronous, active low), the count, the snapshot, the prescaler state and the divide value all become zero, and `tick` and `wrap` are low.
- R2: The prescaler advances once per enabled input cycle. At the edge where its internal count equals the divide value, it returns to zero and drives `tick` high for the following clock cycle. Ticks therefore repeat every divide value + 1 enabled cycles.
- R3: With `src_sel` = 0 every clock cycle is enabled. With `src_sel` = 1 only cycles with `ext_en` high are enabled. With `src_sel` = 1 and `ext_en` low, the prescaler holds and no tick is produced.
- R4: A divide value of zero produces a tick on every enabled cycle.
- R5: A divide write (`div_wr`) stores `div_wdata` and clears the prescaler's internal count to zero in that edge. `tick` is low in the cycle that follows, and the next tick comes divide value + 1 enabled cycles later.
- R6: In a cycle with `tick` high and no counter write, the count increases by exactly one at the next edge. Without a tick, it holds.
- R7: A tick while the count is all ones (0x1_FFFF_FFFF) wraps the count to zero. `wrap` is high for exactly the one cycle in which the wrapped zero is first shown.
- R8: A counter write (`cnt_wr`) with `cnt_wsel` = 0 loads bits [15:0], with 1 loads bits [31:16], and with 2 loads bit [32] from `cnt_wdata[0]`. Code 3 changes nothing. Bits outside the selected word keep their value.
- R9: A counter write in the same cycle as a tick takes the written value. No increment is applied in that cycle.
- R10: A `snap_wr` pulse copies the whole 33-bit count, as it stood before that edge, into the snapshot at once. `snap_w0` = bits [15:0], `snap_w1` = bits [31:16] and `snap_w2` = bit [32]. The snapshot keeps its value until the next `snap_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_sel | input | 1 | Prescaler input: 0 every clock, 1 external enable |
| ext_en | input | 1 | External clock-enable, one cycle per reference edge |
| div_wr | input | 1 | Divide value write strobe |
| div_wdata | input | 14 | New divide value |
| cnt_wr | input | 1 | Live counter write strobe |
| cnt_wsel | input | 2 | Word select for counter write |
| cnt_wdata | input | 16 | Counter write data |
| snap_wr | input | 1 | Snapshot command |
| tick | output | 1 | One-cycle prescaler tick |
| wrap | output | 1 | One-cycle counter wrap pulse |
| live_count | output | 33 | Live counter value |
| snap_w0 | output | 16 | Snapshot bits [15:0] |
| snap_w1 | output | 16 | Snapshot bits [31:16] |
| snap_w2 | output | 1 | Snapshot bit [32] |

## Verification
The assertions check local cycle rules on every cycle:
- the prescaler count never exceeds the divide value;
- the prescaler holds while its input is disabled;
- each tick gives exactly one increment or one wrap;
- a selected word takes the written data;
- the snapshot equals the previous count after a command and holds otherwise.

Properties that span many cycles are shown only by the directed scenarios. These are the tick period for a given divide value, the restart point after a divide write, the counting of sparse external enables, and tear-free snapshot values while the counter runs.

// File: rtl/tbase_pkg.sv
// Package: shared encodings for the prescaled time base.
// Assumes: nothing beyond standard SystemVerilog.
package tbase_pkg;

    // Prescaler input source.
    typedef enum logic {
        SRC_SYS = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    // Word select codes for the live counter write port.
    typedef enum logic [1:0] {
        WSEL_W0   = 2'd0,
        WSEL_W1   = 2'd1,
        WSEL_W2   = 2'd2,
        WSEL_NONE = 2'd3
    } wsel_e;

endpackage

// File: rtl/tbase_prescaler.sv
// Module: tbase_prescaler
// Divides the enabled input cycles by (divide value + 1). It drives a
// registered one-clock tick in the cycle after the enabled edge at which
// its internal count matched the divide value.
// Assumes: ext_en is already synchronous to clk. A divide write wins over
// counting in the same cycle.
module tbase_prescaler
    import tbase_pkg::*;
#(
    parameter int PRE_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_sel,
    input  logic             ext_en,
    input  logic             div_wr,
    input  logic [PRE_W-1:0] div_wdata,
    output logic             tick
);

    logic [PRE_W-1:0] div_q;
    logic [PRE_W-1:0] pre_q;
    logic             tick_q;
    logic             step;
    logic             at_end;

    // Decide whether this cycle counts as an input cycle.
    always_comb begin
        step = (src_sel == SRC_EXT) ? ext_en : 1'b1;
    end

    // Detect that the internal count has reached the divide value.
    always_comb begin
        at_end = (pre_q == div_q);
    end

    // Hold the divide value written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (div_wr) begin
            div_q <= div_wdata;
        end
    end

    // Advance the internal count and make the tick pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_q  <= '0;
            tick_q <= 1'b0;
        end else if (div_wr) begin
            pre_q  <= '0;
            tick_q <= 1'b0;
        end else if (step) begin
            if (at_end) begin
                pre_q  <= '0;
                tick_q <= 1'b1;
            end else begin
                pre_q  <= pre_q + 1'b1;
                tick_q <= 1'b0;
            end
        end else begin
            tick_q <= 1'b0;
        end
    end

    assign tick = tick_q;

    // R2
    pre_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_q <= div_q);

    // R3
    src_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel && !ext_en && !div_wr) |=> ($stable(pre_q) && !tick));

    // R5
    div_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_wr |=> (pre_q == '0 && !tick));

endmodule

// File: rtl/tbase_counter.sv
// Module: tbase_counter
// Free-running up-counter that advances once per tick and wraps to zero
// after all ones, with a one-cycle wrap pulse. A word-wise write port
// overwrites one word and blocks the increment in that cycle.
// Assumes: CNT_W fits in three words of WORD_W bits.
module tbase_counter
    import tbase_pkg::*;
#(
    parameter int CNT_W  = 33,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cnt_wr,
    input  logic [1:0]        cnt_wsel,
    input  logic [WORD_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0]  count,
    output logic              wrap
);

    localparam int NWORDS = (CNT_W + WORD_W - 1) / WORD_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] wmask;
    logic [CNT_W-1:0] wval;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] cnt_d;
    logic             wrap_q;
    logic             bump;

    // Build per-word write mask and data slices.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        localparam int LO = w * WORD_W;
        localparam int HI = (LO + WORD_W - 1 < CNT_W - 1) ? (LO + WORD_W - 1) : (CNT_W - 1);
        localparam int WW = HI - LO + 1;
        assign wmask[HI:LO] = {WW{cnt_wr && (cnt_wsel == 2'(w))}};
        assign wval[HI:LO]  = cnt_wdata[WW-1:0];
    end

    // Increment only when a tick arrives and no write is pending.
    always_comb begin
        bump = tick && !cnt_wr;
    end

    // Form the next count: increment base merged with written word.
    always_comb begin
        base  = bump ? (cnt_q + 1'b1) : cnt_q;
        cnt_d = (wmask & wval) | (~wmask & base);
    end

    // Register the count and the wrap pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            wrap_q <= bump && (cnt_q == CNT_MAX);
        end
    end

    assign count = cnt_q;
    assign wrap  = wrap_q;

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1 && !wrap));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> ($stable(cnt_q) && !wrap));

    // R7
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt_q == CNT_MAX) |=> (cnt_q == '0 && wrap));

    // R8
    low_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cnt_wsel == WSEL_W0) |=>
            (cnt_q[WORD_W-1:0] == $past(cnt_wdata) && cnt_q[CNT_W-1:WORD_W] == $past(cnt_q[CNT_W-1:WORD_W])));

    // R9
    write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_wr && cnt_wsel == WSEL_NONE) |=> ($stable(cnt_q) && !wrap));

endmodule

// File: rtl/tbase_snapshot.sv
// Module: tbase_snapshot
// Shadow register that captures the whole count in a single edge when
// commanded, so that a multi-word read sees one coherent value.
// Assumes: the count is the registered live value; the capture takes the
// value from before the same edge's update.
module tbase_snapshot #(
    parameter int CNT_W = 33
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snap_wr,
    input  logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] snap
);

    logic [CNT_W-1:0] snap_q;

    // Capture the full count on command, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (snap_wr) begin
            snap_q <= count;
        end
    end

    assign snap = snap_q;

    // R10
    snap_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_wr |=> (snap_q == $past(count)));

    // R10
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_wr |=> $stable(snap_q));

endmodule

// File: rtl/tick_timebase.sv
// Module: tick_timebase (top)
// Prescaler, up-counter and snapshot register joined into one time base.
// The tick output is meant as a rate enable for neighbouring blocks.
// Assumes: CNT_W lies between 2*WORD_W+1 and 3*WORD_W; all inputs are
// synchronous to clk.
module tick_timebase #(
    parameter int PRE_W  = 14,
    parameter int CNT_W  = 33,
    parameter int WORD_W = 16,
    localparam int TOP_W = CNT_W - 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_sel,
    input  logic              ext_en,
    input  logic              div_wr,
    input  logic [PRE_W-1:0]  div_wdata,
    input  logic              cnt_wr,
    input  logic [1:0]        cnt_wsel,
    input  logic [WORD_W-1:0] cnt_wdata,
    input  logic              snap_wr,
    output logic              tick,
    output logic              wrap,
    output logic [CNT_W-1:0]  live_count,
    output logic [WORD_W-1:0] snap_w0,
    output logic [WORD_W-1:0] snap_w1,
    output logic [TOP_W-1:0]  snap_w2
);

    logic             tick_i;
    logic [CNT_W-1:0] count_i;
    logic [CNT_W-1:0] snap_i;

    // Rate divider.
    tbase_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_sel   (src_sel),
        .ext_en    (ext_en),
        .div_wr    (div_wr),
        .div_wdata (div_wdata),
        .tick      (tick_i)
    );

    // Live counter.
    tbase_counter #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick_i),
        .cnt_wr    (cnt_wr),
        .cnt_wsel  (cnt_wsel),
        .cnt_wdata (cnt_wdata),
        .count     (count_i),
        .wrap      (wrap)
    );

    // Coherent shadow copy.
    tbase_snapshot #(.CNT_W(CNT_W)) u_snap (
        .clk     (clk),
        .rst_n   (rst_n),
        .snap_wr (snap_wr),
        .count   (count_i),
        .snap    (snap_i)
    );

    assign tick       = tick_i;
    assign live_count = count_i;
    assign snap_w0    = snap_i[WORD_W-1:0];
    assign snap_w1    = snap_i[2*WORD_W-1:WORD_W];
    assign snap_w2    = snap_i[CNT_W-1:2*WORD_W];

endmodule

// File: tb/tick_timebase_test.sv
`timescale 1ns/1ps
module tick_timebase_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        src_sel = 1'b0;
    logic        ext_en = 1'b0;
    logic        div_wr = 1'b0;
    logic [13:0] div_wdata = '0;
    logic        cnt_wr = 1'b0;
    logic [1:0]  cnt_wsel = '0;
    logic [15:0] cnt_wdata = '0;
    logic        snap_wr = 1'b0;
    logic        tick;
    logic        wrap;
    logic [32:0] live_count;
    logic [15:0] snap_w0;
    logic [15:0] snap_w1;
    logic [0:0]  snap_w2;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tick_timebase uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .ext_en     (ext_en),
        .div_wr     (div_wr),
        .div_wdata  (div_wdata),
        .cnt_wr     (cnt_wr),
        .cnt_wsel   (cnt_wsel),
        .cnt_wdata  (cnt_wdata),
        .snap_wr    (snap_wr),
        .tick       (tick),
        .wrap       (wrap),
        .live_count (live_count),
        .snap_w0    (snap_w0),
        .snap_w1    (snap_w1),
        .snap_w2    (snap_w2)
    );

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    // Stop all counting: external source with enable low, let ticks drain.
    task automatic freeze();
        src_sel = 1'b1;
        ext_en  = 1'b0;
        nxt();
        nxt();
    endtask

    // Write the divide value, then pick the source for what follows.
    task automatic load_div(int r, bit use_sys);
        div_wr    = 1'b1;
        div_wdata = 14'(r);
        nxt();
        div_wr  = 1'b0;
        src_sel = use_sys ? 1'b0 : 1'b1;
    endtask

    task automatic wr_word(logic [1:0] sel, logic [15:0] d);
        cnt_wr    = 1'b1;
        cnt_wsel  = sel;
        cnt_wdata = d;
        nxt();
        cnt_wr = 1'b0;
    endtask

    task automatic wr_count(logic [32:0] v);
        wr_word(2'd0, v[15:0]);
        wr_word(2'd1, v[31:16]);
        wr_word(2'd2, {15'd0, v[32]});
    endtask

    task automatic t_reset();
        repeat (3) nxt();
        chk("R1 count", 64'(live_count), 64'h0);
        chk("R1 tick", 64'(tick), 64'h0);
        chk("R1 wrap", 64'(wrap), 64'h0);
        chk("R1 snapshot", 64'({snap_w2, snap_w1, snap_w0}), 64'h0);
        rst_n = 1'b1;
        nxt();
        chk("R1 zero divide ticks", 64'(tick), 64'h1);
    endtask

    task automatic t_period(int r, string req);
        logic [32:0] c0;
        freeze();
        c0 = live_count;
        load_div(r, 1'b1);
        for (int i = 1; i <= 2 * (r + 1); i++) begin
            nxt();
            chk(req, 64'(tick), 64'((i % (r + 1)) == 0));
        end
        chk("R6 count per tick", 64'(live_count), 64'(c0 + 33'd1));
    endtask

    task automatic t_ext();
        int pat[10] = '{1, 0, 0, 1, 0, 1, 0, 1, 1, 1};
        int en = 0;
        logic [32:0] c0;
        freeze();
        load_div(2, 1'b0);
        c0 = live_count;
        for (int k = 0; k < 10; k++) begin
            ext_en = pat[k][0];
            nxt();
            if (pat[k] != 0) en++;
            chk("R3 external enable", 64'(tick), 64'((pat[k] != 0) && (en % 3 == 0)));
        end
        ext_en = 1'b0;
        nxt();
        chk("R3 ticks counted", 64'(live_count), 64'(c0 + 33'd2));
        nxt();
        chk("R3 held when disabled", 64'(live_count), 64'(c0 + 33'd2));
    endtask

    task automatic t_restart();
        freeze();
        load_div(4, 1'b1);
        repeat (3) nxt();
        div_wr    = 1'b1;
        div_wdata = 14'd4;
        nxt();
        div_wr = 1'b0;
        chk("R5 no tick after write", 64'(tick), 64'h0);
        for (int i = 1; i <= 5; i++) begin
            nxt();
            chk("R5 restart period", 64'(tick), 64'(i == 5));
        end
    endtask

    task automatic t_wrap();
        freeze();
        wr_count(33'h1_FFFF_FFFE);
        load_div(0, 1'b1);
        nxt();
        chk("R7 before max", 64'(live_count), 64'h1_FFFF_FFFE);
        nxt();
        chk("R7 at max", 64'(live_count), 64'h1_FFFF_FFFF);
        chk("R7 no early wrap", 64'(wrap), 64'h0);
        nxt();
        chk("R7 wrapped count", 64'(live_count), 64'h0);
        chk("R7 wrap pulse", 64'(wrap), 64'h1);
        nxt();
        chk("R7 after wrap", 64'(live_count), 64'h1);
        chk("R7 pulse one cycle", 64'(wrap), 64'h0);
    endtask

    task automatic t_priority();
        freeze();
        wr_count(33'h100);
        load_div(0, 1'b1);
        nxt();
        chk("R9 tick active", 64'(tick), 64'h1);
        cnt_wr    = 1'b1;
        cnt_wsel  = 2'd0;
        cnt_wdata = 16'hABCD;
        nxt();
        cnt_wr = 1'b0;
        chk("R9 write beats tick", 64'(live_count), 64'hABCD);
        nxt();
        chk("R6 counts after write", 64'(live_count), 64'hABCE);
    endtask

    task automatic t_partial();
        freeze();
        wr_count(33'h1_2345_6789);
        chk("R8 full write", 64'(live_count), 64'h1_2345_6789);
        wr_word(2'd1, 16'hAAAA);
        chk("R8 word1 only", 64'(live_count), 64'h1_AAAA_6789);
        wr_word(2'd2, 16'hFFFE);
        chk("R8 word2 from bit0", 64'(live_count), 64'h0_AAAA_6789);
        wr_word(2'd3, 16'h5555);
        chk("R8 code3 no effect", 64'(live_count), 64'h0_AAAA_6789);
    endtask

    task automatic t_snap();
        logic [32:0] lv;
        freeze();
        wr_count(33'h1_0F0F_F0F0);
        snap_wr = 1'b1;
        nxt();
        snap_wr = 1'b0;
        chk("R10 word0", 64'(snap_w0), 64'hF0F0);
        chk("R10 word1", 64'(snap_w1), 64'h0F0F);
        chk("R10 word2", 64'(snap_w2), 64'h1);
        wr_count(33'h0);
        chk("R10 holds", 64'({snap_w2, snap_w1, snap_w0}), 64'h1_0F0F_F0F0);
        load_div(0, 1'b1);
        nxt();
        nxt();
        lv = live_count;
        snap_wr = 1'b1;
        nxt();
        snap_wr = 1'b0;
        chk("R10 running capture", 64'({snap_w2, snap_w1, snap_w0}), 64'(lv));
        chk("R10 live moved on", 64'(live_count), 64'(lv + 33'd1));
    endtask

    initial begin
        t_reset();
        t_period(3, "R2 period");
        t_period(0, "R4 zero divide");
        t_ext();
        t_restart();
        t_wrap();
        t_priority();
        t_partial();
        t_snap();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule